// File: doc/BRIEF.md
# Windowed Watchdog with Qualified Enable

This block supervises software activity with a watchdog that sets both a lower and an upper bound on the service interval. Once the supervisor's ready flag is high, each period starts with a closed window and continues with an open window. A falling edge on the service line inside the open window restarts the period. A falling edge inside the closed window is a failure. So is reaching the end of the open window with no service. Either failure drives a short active-low reset pulse, and a fresh period follows. With no service at all, the reset output becomes a repeating pulse train.

A second active-low output, the system enable, guards critical functions. It is driven low only after a run of consecutive correct services. It returns high at once on any failure, on any reset pulse, or when the ready flag drops. All window lengths count a free-running tick input, so the host chooses the time base. The window lengths and the pulse width are worked out at elaboration from a nominal period and an open-window percentage.

Top module: `window_watchdog`

## Requirements
- R1: While `ready` is low (and during `rst_n`), `wd_rst_n` is 0 and `sys_en_n` is 1. Service edges seen in that time have no effect on the timing once `ready` rises. The cycle in which `ready` is first sampled high starts a closed window.
- R2: The closed window lasts CW = TWD − ⌊TWD·OWP/100⌋ ticks. A service edge acted on in it starts a reset pulse in the same edge.
- R3: The open window follows and lasts OW = 2·⌊TWD·OWP/100⌋ ticks. A service edge acted on in it (up to and including its last tick) restarts the closed window without a pulse.
- R4: If the open window ends with no service, `wd_rst_n` goes low for PW = max(1, ⌊(TWD+20)/40⌋) ticks, which is TWD/40 rounded half up. An early-service pulse has the same width.
- R5: After a pulse a new closed window starts, so with no service the output repeats with period CW+OW+PW ticks.
- R6: Window and pulse timers advance only in cycles where `tick` is 1.
- R7: `sys_en_n` is 1 whenever `wd_rst_n` is 0. It goes to 0 only after SVC_NEED consecutive in-window services, and the count saturates at SVC_NEED. An early service or a timeout clears the count.
- R8: A low `ready` forces `sys_en_n` to 1 in the same cycle (combinationally) and `wd_rst_n` to 0 from the next clock edge.
- R9: Service edges that arrive while a reset pulse is being driven are ignored; the pulse keeps its width.
- R10: `svc_n` passes through SYNC_STAGES flip-flops. Only a high-to-low transition counts as a service, so a rising edge has no effect. A falling edge on `svc_n` takes effect SYNC_STAGES+1 clock edges after the first edge that samples it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the host |
| tick | input | 1 | Time-base strobe; timers count cycles where it is 1 |
| ready | input | 1 | Power-up sequence complete flag from the supervisor |
| svc_n | input | 1 | Asynchronous service line; a falling edge services the watchdog |
| wd_rst_n | output | 1 | Active-low watchdog reset |
| sys_en_n | output | 1 | Active-low system enable |

## Verification
The main function is tried with a sweep that places a single service edge at every possible tick offset from the start of a window. This shows exactly where the closed/open boundary and the end of the open window fall. For every in-window offset, the bench also checks that the next timeout arrives a full CW+OW later. This separates a real restart from a service that was only tolerated. Runs with no service, with a service during the pulse, with a rising-only edge, and with the tick held off show apart the repeating pulse train, the pulse width, the edge polarity and the tick gating. Service sequences that are broken by an early edge or a timeout show whether the enable count is cleared or only paused.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  typedef enum logic [1:0] {
    PH_WAIT   = 2'd0,
    PH_CLOSED = 2'd1,
    PH_OPEN   = 2'd2,
    PH_FIRE   = 2'd3
  } wwd_phase_e;

  function automatic int unsigned margin_len(input int unsigned twd, input int unsigned owp);
    return (twd * owp) / 100;
  endfunction

  function automatic int unsigned closed_len(input int unsigned twd, input int unsigned owp);
    return twd - margin_len(twd, owp);
  endfunction

  function automatic int unsigned open_len(input int unsigned twd, input int unsigned owp);
    return 2 * margin_len(twd, owp);
  endfunction

  // twd/40 rounded half up, never below one tick
  function automatic int unsigned pulse_len(input int unsigned twd);
    int unsigned p;
    p = (twd + 20) / 40;
    if (p == 0) p = 1;
    return p;
  endfunction

endpackage

// File: rtl/wwd_sync_fall.sv
module wwd_sync_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = din;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/wwd_phase_fsm.sv
module wwd_phase_fsm
  import wwd_pkg::*;
#(
  parameter int unsigned CW_TICKS = 80,
  parameter int unsigned OW_TICKS = 40,
  parameter int unsigned PW_TICKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready,
  input  logic       tick,
  input  logic       svc_fall,
  output wwd_phase_e phase_o,
  output logic       good_o,
  output logic       bad_o
);
  localparam int unsigned MAXLEN = (CW_TICKS > OW_TICKS)
                                   ? ((CW_TICKS > PW_TICKS) ? CW_TICKS : PW_TICKS)
                                   : ((OW_TICKS > PW_TICKS) ? OW_TICKS : PW_TICKS);
  localparam int unsigned TW = $clog2(MAXLEN + 1);
  localparam logic [TW-1:0] CW_LAST = TW'(CW_TICKS - 1);
  localparam logic [TW-1:0] OW_LAST = TW'(OW_TICKS - 1);
  localparam logic [TW-1:0] PW_LAST = TW'(PW_TICKS - 1);

  wwd_phase_e phase_q, phase_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          upd_en;

  always_comb begin
    phase_d = phase_q;
    tmr_d   = tmr_q;
    good_o  = 1'b0;
    bad_o   = 1'b0;
    if (!ready) begin
      phase_d = PH_WAIT;
      tmr_d   = '0;
    end else begin
      unique case (phase_q)
        PH_WAIT: begin
          phase_d = PH_CLOSED;
          tmr_d   = '0;
        end
        PH_CLOSED: begin
          if (svc_fall) begin
            phase_d = PH_FIRE;
            tmr_d   = '0;
            bad_o   = 1'b1;
          end else if (tick) begin
            if (tmr_q == CW_LAST) begin
              phase_d = PH_OPEN;
              tmr_d   = '0;
            end else begin
              tmr_d = tmr_q + 1'b1;
            end
          end
        end
        PH_OPEN: begin
          if (svc_fall) begin
            phase_d = PH_CLOSED;
            tmr_d   = '0;
            good_o  = 1'b1;
          end else if (tick) begin
            if (tmr_q == OW_LAST) begin
              phase_d = PH_FIRE;
              tmr_d   = '0;
              bad_o   = 1'b1;
            end else begin
              tmr_d = tmr_q + 1'b1;
            end
          end
        end
        PH_FIRE: begin
          if (tick) begin
            if (tmr_q == PW_LAST) begin
              phase_d = PH_CLOSED;
              tmr_d   = '0;
            end else begin
              tmr_d = tmr_q + 1'b1;
            end
          end
        end
        default: begin
          phase_d = PH_WAIT;
          tmr_d   = '0;
        end
      endcase
    end
  end

  assign upd_en = (phase_d != phase_q) || (tmr_d != tmr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
      tmr_q   <= '0;
    end else if (upd_en) begin
      phase_q <= phase_d;
      tmr_q   <= tmr_d;
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/wwd_svc_tally.sv
module wwd_svc_tally #(
  parameter int unsigned NEED = 3,
  localparam int unsigned CNTW = $clog2(NEED + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ready,
  input  logic            good_i,
  input  logic            bad_i,
  output logic [CNTW-1:0] cnt_o,
  output logic            full_o
);
  localparam logic [CNTW-1:0] TOP = CNTW'(NEED);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (!ready || bad_i) begin
      cnt_d = '0;
    end else if (good_i && (cnt_q != TOP)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == TOP);

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wwd_pkg::*;
#(
  parameter int unsigned TWD_TICKS   = 100,
  parameter int unsigned OWP_PCT     = 20,
  parameter int unsigned SVC_NEED    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ready,
  input  logic svc_n,
  output logic wd_rst_n,
  output logic sys_en_n
);
  localparam int unsigned CW_TICKS = closed_len(TWD_TICKS, OWP_PCT);
  localparam int unsigned OW_TICKS = open_len(TWD_TICKS, OWP_PCT);
  localparam int unsigned PW_TICKS = pulse_len(TWD_TICKS);
  localparam int unsigned CNTW     = $clog2(SVC_NEED + 1);

  logic            svc_fall;
  wwd_phase_e      phase;
  logic            good_evt;
  logic            bad_evt;
  logic [CNTW-1:0] svc_cnt;
  logic            qualified;

  wwd_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (svc_n),
    .fall_o (svc_fall)
  );

  wwd_phase_fsm #(
    .CW_TICKS (CW_TICKS),
    .OW_TICKS (OW_TICKS),
    .PW_TICKS (PW_TICKS)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .tick     (tick),
    .svc_fall (svc_fall),
    .phase_o  (phase),
    .good_o   (good_evt),
    .bad_o    (bad_evt)
  );

  wwd_svc_tally #(.NEED(SVC_NEED)) u_tally (
    .clk    (clk),
    .rst_n  (rst_n),
    .ready  (ready),
    .good_i (good_evt),
    .bad_i  (bad_evt),
    .cnt_o  (svc_cnt),
    .full_o (qualified)
  );

  assign wd_rst_n = (phase == PH_CLOSED) || (phase == PH_OPEN);
  assign sys_en_n = ~(qualified & ready & wd_rst_n);

endmodule

// File: rtl/wwd_checker.sv
module wwd_checker #(
  parameter int unsigned NEED = 3,
  localparam int unsigned CNTW = $clog2(NEED + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ready,
  input logic            wd_rst_n,
  input logic            sys_en_n,
  input logic [CNTW-1:0] svc_cnt
);
  // R8
  ready_drop_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> sys_en_n);

  // R1
  wait_holds_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !wd_rst_n);

  // R7
  en_off_in_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_rst_n |-> sys_en_n);

  // R7
  tally_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_cnt <= CNTW'(NEED));

  // R7
  en_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_en_n) |-> ($past(svc_cnt) == CNTW'(NEED - 1)));

endmodule

bind window_watchdog wwd_checker #(.NEED(SVC_NEED)) u_wwd_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ready    (ready),
  .wd_rst_n (wd_rst_n),
  .sys_en_n (sys_en_n),
  .svc_cnt  (svc_cnt)
);

// File: tb/tb_window_watchdog.sv
module tb_window_watchdog;
  localparam int TWD  = 80;
  localparam int OWP  = 25;
  localparam int CW   = 60;   // 80 - 20
  localparam int OW   = 40;   // 2 * 20
  localparam int PW   = 2;    // 80/40
  localparam int NEED = 3;
  localparam int LAT  = 3;    // two sync stages plus edge register

  logic clk = 1'b0;
  logic rst_n, tick, ready, svc_n;
  logic wd_rst_n, sys_en_n;
  int   checks = 0;
  int   errors = 0;
  int   ph = 0;

  always #2 clk = ~clk;

  window_watchdog #(
    .TWD_TICKS(TWD), .OWP_PCT(OWP), .SVC_NEED(NEED), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ready(ready), .svc_n(svc_n),
    .wd_rst_n(wd_rst_n), .sys_en_n(sys_en_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (phase offset %0d)", req, act, exp, ph);
    end
  endtask

  task automatic adv(input int k);
    repeat (k) @(negedge clk);
    ph += k;
  endtask

  task automatic restart(input logic svc_level);
    @(negedge clk);
    ready = 1'b0;
    svc_n = svc_level;
    tick  = 1'b1;
    repeat (4) @(negedge clk);
    ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ph = 0;
  endtask

  task automatic serve_at(input int j);
    adv(j - LAT - ph);
    svc_n = 1'b0;
    adv(LAT);
    svc_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ready = 1'b0; tick = 1'b0; svc_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset rst", wd_rst_n, 1'b0);
    chk("R1 reset en", sys_en_n, 1'b1);
    rst_n = 1'b1;
    adv(3);
    chk("R1 not ready rst", wd_rst_n, 1'b0);
    chk("R1 not ready en", sys_en_n, 1'b1);

    // Sweep service offset over every tick of both windows
    for (int j = LAT; j <= CW + OW; j++) begin
      restart(1'b1);
      serve_at(j);
      if (j <= CW) begin
        chk("R2 early service pulses", wd_rst_n, 1'b0);
        adv(PW - 1);
        chk("R4 early pulse width low", wd_rst_n, 1'b0);
        adv(1);
        chk("R4 early pulse width end", wd_rst_n, 1'b1);
      end else begin
        chk("R3 in-window no pulse", wd_rst_n, 1'b1);
        ph = 0;
        adv(CW + OW - 1);
        chk("R3 restart before timeout", wd_rst_n, 1'b1);
        adv(1);
        chk("R3 restart timeout point", wd_rst_n, 1'b0);
      end
    end

    // Timeout and repeating pulse train
    restart(1'b1);
    adv(CW + OW - 1);
    chk("R4 open end not yet", wd_rst_n, 1'b1);
    adv(1);
    chk("R4 timeout pulse", wd_rst_n, 1'b0);
    chk("R7 en during pulse", sys_en_n, 1'b1);
    adv(PW - 1);
    chk("R4 pulse still low", wd_rst_n, 1'b0);
    adv(1);
    chk("R5 pulse released", wd_rst_n, 1'b1);
    ph = 0;
    adv(CW + OW - 1);
    chk("R5 second period high", wd_rst_n, 1'b1);
    adv(1);
    chk("R5 second pulse", wd_rst_n, 1'b0);

    // Service during pulse ignored
    restart(1'b1);
    adv(CW + OW - 2);
    svc_n = 1'b0;
    adv(2);
    chk("R9 timeout pulse", wd_rst_n, 1'b0);
    adv(1);
    chk("R9 pulse held", wd_rst_n, 1'b0);
    adv(1);
    chk("R9 pulse width kept", wd_rst_n, 1'b1);
    svc_n = 1'b1;
    adv(5);
    chk("R9 no extra pulse", wd_rst_n, 1'b1);

    // Fall while not ready ignored; rising edge in open window ignored
    restart(1'b0);
    adv(3);
    chk("R1 fall while waiting ignored", wd_rst_n, 1'b1);
    adv(CW + 5 - ph);
    svc_n = 1'b1;
    adv(CW + OW - 1 - ph);
    chk("R10 rising edge no restart", wd_rst_n, 1'b1);
    adv(1);
    chk("R10 timeout after rising edge", wd_rst_n, 1'b0);

    // Tick gating
    @(negedge clk);
    ready = 1'b0; svc_n = 1'b1; tick = 1'b0;
    repeat (4) @(negedge clk);
    ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ph = 0;
    adv(200);
    chk("R6 no tick no timeout", wd_rst_n, 1'b1);
    tick = 1'b1;
    ph = 0;
    adv(CW + OW - 1);
    chk("R6 ticks counted", wd_rst_n, 1'b1);
    adv(1);
    chk("R6 timeout after ticks", wd_rst_n, 1'b0);

    // Enable qualification and saturation
    restart(1'b1);
    for (int s = 1; s <= NEED + 1; s++) begin
      serve_at(CW + 5);
      ph = 0;
      chk("R7 enable after run", sys_en_n, (s >= NEED) ? 1'b0 : 1'b1);
    end
    ready = 1'b0;
    #1;
    chk("R8 dropout enable at once", sys_en_n, 1'b1);
    adv(1);
    chk("R8 dropout reset", wd_rst_n, 1'b0);

    // Early service clears run
    restart(1'b1);
    for (int s = 1; s <= NEED; s++) begin
      serve_at(CW + 5);
      ph = 0;
    end
    chk("R7 enabled", sys_en_n, 1'b0);
    serve_at(10);
    chk("R7 early drops enable", sys_en_n, 1'b1);
    chk("R2 early pulse", wd_rst_n, 1'b0);
    adv(PW);
    ph = 0;
    for (int s = 1; s <= NEED; s++) begin
      serve_at(CW + 5);
      ph = 0;
      chk("R7 run restarts after early", sys_en_n, (s >= NEED) ? 1'b0 : 1'b1);
    end

    // Timeout clears run
    adv(CW + OW);
    chk("R7 timeout drops enable", sys_en_n, 1'b1);
    adv(PW);
    ph = 0;
    serve_at(CW + 5);
    chk("R7 one service after timeout", sys_en_n, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule